// File: doc/BRIEF.md
# Row-Burst Spike Event Transmitter

This block gathers spike requests from a two-dimensional array of neurons and ships them off chip as word-serial address bursts. Every neuron has a sticky pending flag. Each flag is set by a one-cycle pulse on its bit of `spike_in`. When the block is idle and any flag is pending, a round-robin arbiter picks one row. That row's flags are captured into a burst snapshot and cleared in the same edge. The block then sends the words of the burst one at a time. It waits for the receiver to toggle `ack` before moving past each word.

A burst opens when `burst_req` goes high with the chip word, which is always zero for locally generated events. The row word follows. Then comes one column word for each captured neuron, in ascending column order. Each of these later words is announced by a falling edge of the active-low `word_req_n`. The burst closes when `burst_req` drops after the last column word has been acknowledged. A spike that arrives in the selected row after the snapshot is taken stays pending for a later burst. It never joins the burst already in flight.

Top module: `aer_burst_tx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `burst_req` is 0, `word_req_n` is 1 and `addr` is 0.
- R2: A burst starts with `burst_req` rising while `word_req_n` is 1 and `addr` is 0 (the chip word).
- R3: After the chip word is acknowledged, the next clock drives `addr` to the selected row index and drives `word_req_n` low.
- R4: Column words carry the column index of each captured neuron in ascending order, one word per neuron. Before each column word, `word_req_n` is high for exactly one cycle. `word_req_n` is low only while `burst_req` is high.
- R5: A presented word and its request level are held unchanged until `ack` differs from its value on the previous clock. The level of `ack` by itself has no effect.
- R6: On the clock after the last column word's acknowledge toggle, `burst_req` falls, `word_req_n` goes to 1 and `addr` returns to 0.
- R7: The snapshot is the row's flags as registered before the selecting clock. Spikes into that row on or after that clock are kept pending and sent in a later burst.
- R8: Rows with pending flags are served round-robin, searching from the row after the last one served. After reset the search starts at row 0.
- R9: Flags that were sent are cleared, so a neuron that does not spike again is not sent again.
- R10: Repeated pulses to a neuron that is already pending produce a single column word.
- Neuron (r, c) is bit r*COLS+c of `spike_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spike_in | input | ROWS*COLS | One-cycle spike pulses, bit r*COLS+c for neuron (r, c) |
| ack | input | 1 | Acknowledge; each transition accepts the current word |
| burst_req | output | 1 | High for the duration of a burst |
| word_req_n | output | 1 | Active-low request for every word after the chip word |
| addr | output | max(clog2 ROWS, clog2 COLS) | Word being sent: chip, row or column |

## Verification
The bench fires several neurons in one row at once and checks that they appear in one burst in ascending column order. A design that dropped the one-cycle gap, or scanned the columns backwards, would show missing request edges or a reordered log. It re-fires neurons in a row whose burst is already running, to catch a design that merges late spikes into the current burst or loses them when it clears the row. It sets up pending rows on both sides of the last served row to expose a fixed-priority arbiter or a pointer that does not wrap. It also varies the acknowledge delay, which would reveal a transmitter that advances on the `ack` level or runs ahead of the receiver.

// File: rtl/aer_tx_pkg.sv
package aer_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CHIP = 2'd1,
    ST_WORD = 2'd2,
    ST_GAP  = 2'd3
  } tx_state_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/aer_spike_store.sv
module aer_spike_store #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW = aer_tx_pkg::idx_bits(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROWS*COLS-1:0] spike_in,
  input  logic                 clr_en,
  input  logic [RW-1:0]        clr_row,
  output logic [ROWS*COLS-1:0] flags,
  output logic [ROWS-1:0]      row_pend
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)
        flags[r*COLS +: COLS] <= '0;
      else if (clr_en && (clr_row == RW'(r)))
        flags[r*COLS +: COLS] <= spike_in[r*COLS +: COLS];
      else
        flags[r*COLS +: COLS] <= flags[r*COLS +: COLS] | spike_in[r*COLS +: COLS];
    end
    assign row_pend[r] = |flags[r*COLS +: COLS];
  end
endmodule

// File: rtl/aer_rr_arbiter.sv
module aer_rr_arbiter #(
  parameter int N = 8,
  localparam int IW = aer_tx_pkg::idx_bits(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] gnt,
  output logic          gnt_ok
);
  always_comb begin
    gnt    = '0;
    gnt_ok = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last) + k) % N;
      if (!gnt_ok && req[j]) begin
        gnt_ok = 1'b1;
        gnt    = IW'(j);
      end
    end
  end
endmodule

// File: rtl/aer_low_pick.sv
module aer_low_pick #(
  parameter int W = 8,
  localparam int IW = aer_tx_pkg::idx_bits(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--)
      if (vec[i]) idx = IW'(i);
    any = |vec;
  end
endmodule

// File: rtl/aer_burst_tx.sv
module aer_burst_tx #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW = aer_tx_pkg::idx_bits(ROWS),
  localparam int CW = aer_tx_pkg::idx_bits(COLS),
  localparam int AW = aer_tx_pkg::max2(RW, CW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ROWS*COLS-1:0] spike_in,
  input  logic                 ack,
  output logic                 burst_req,
  output logic                 word_req_n,
  output logic [AW-1:0]        addr
);
  import aer_tx_pkg::*;

  tx_state_e            state;
  logic                 ack_q;
  logic                 ack_tog;
  logic [RW-1:0]        cur_row;
  logic [RW-1:0]        last_row;
  logic [COLS-1:0]      rem;
  logic [ROWS*COLS-1:0] flags;
  logic [ROWS-1:0]      row_pend;
  logic [RW-1:0]        gnt_row;
  logic                 gnt_ok;
  logic                 take;
  logic [CW-1:0]        nxt_col;
  logic                 nxt_any;
  logic [COLS-1:0]      sel_flags;

  assign ack_tog   = ack ^ ack_q;
  assign take      = (state == ST_IDLE) && gnt_ok;
  assign sel_flags = flags[int'(gnt_row)*COLS +: COLS];

  aer_spike_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk(clk), .rst(rst), .spike_in(spike_in),
    .clr_en(take), .clr_row(gnt_row),
    .flags(flags), .row_pend(row_pend)
  );

  aer_rr_arbiter #(.N(ROWS)) u_arb (
    .req(row_pend), .last(last_row), .gnt(gnt_row), .gnt_ok(gnt_ok)
  );

  aer_low_pick #(.W(COLS)) u_pick (
    .vec(rem), .idx(nxt_col), .any(nxt_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ack_q      <= 1'b0;
      cur_row    <= '0;
      last_row   <= RW'(ROWS - 1);
      rem        <= '0;
      burst_req  <= 1'b0;
      word_req_n <= 1'b1;
      addr       <= '0;
    end else begin
      ack_q <= ack;
      unique case (state)
        ST_IDLE: if (take) begin
          cur_row    <= gnt_row;
          last_row   <= gnt_row;
          rem        <= sel_flags;
          burst_req  <= 1'b1;
          word_req_n <= 1'b1;
          addr       <= '0;
          state      <= ST_CHIP;
        end
        ST_CHIP: if (ack_tog) begin
          addr       <= AW'(cur_row);
          word_req_n <= 1'b0;
          state      <= ST_WORD;
        end
        ST_WORD: if (ack_tog) begin
          word_req_n <= 1'b1;
          if (nxt_any) begin
            state <= ST_GAP;
          end else begin
            burst_req <= 1'b0;
            addr      <= '0;
            state     <= ST_IDLE;
          end
        end
        ST_GAP: begin
          addr         <= AW'(nxt_col);
          rem[nxt_col] <= 1'b0;
          word_req_n   <= 1'b0;
          state        <= ST_WORD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aer_burst_tx_chk.sv
module aer_burst_tx_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          ack,
  input logic          burst_req,
  input logic          word_req_n,
  input logic [AW-1:0] addr
);
  logic ack_prev;
  always_ff @(posedge clk) begin
    if (rst) ack_prev <= 1'b0;
    else     ack_prev <= ack;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!burst_req && word_req_n && addr == '0));

  p_chip_word_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_req) |-> (word_req_n && addr == '0));

  p_wreq_inside_r4: assert property (@(posedge clk) disable iff (rst)
    !word_req_n |-> burst_req);

  p_one_cycle_gap_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(word_req_n) && burst_req) |=> !word_req_n);

  p_hold_word_r5: assert property (@(posedge clk) disable iff (rst)
    (!word_req_n && ack == ack_prev) |=> (!word_req_n && $stable(addr)));

  p_burst_end_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(burst_req) |-> (word_req_n && $past(!word_req_n)));
endmodule

bind aer_burst_tx aer_burst_tx_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ack(ack),
  .burst_req(burst_req), .word_req_n(word_req_n), .addr(addr)
);

// File: tb/test_aer_burst_tx.sv
module test_aer_burst_tx;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int AW = 3;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [ROWS*COLS-1:0] spike_in = '0;
  logic                 ack = 1'b0;
  logic                 burst_req;
  logic                 word_req_n;
  logic [AW-1:0]        addr;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aer_burst_tx #(.ROWS(ROWS), .COLS(COLS)) i_aer_burst_tx (
    .clk(clk), .rst(rst), .spike_in(spike_in), .ack(ack),
    .burst_req(burst_req), .word_req_n(word_req_n), .addr(addr)
  );

  // reference model: pending bits, a column queue, a phase counter
  bit m_flag [ROWS][COLS];
  int m_phase = 0;
  int m_row = 0;
  int m_last = ROWS - 1;
  int m_cols[$];
  bit m_breq = 0;
  bit m_wreqn = 1;
  int m_addr = 0;
  bit m_ackq = 0;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_flag[r, c]) m_flag[r][c] = 0;
      m_phase = 0; m_last = ROWS - 1; m_cols.delete();
      m_breq = 0; m_wreqn = 1; m_addr = 0; m_ackq = 0;
    end else begin
      bit tog;
      tog = (ack != m_ackq);
      case (m_phase)
        0: begin
          int pick;
          pick = -1;
          for (int k = 1; k <= ROWS; k++) begin
            int r;
            r = (m_last + k) % ROWS;
            if (pick < 0)
              for (int c = 0; c < COLS; c++)
                if (m_flag[r][c]) pick = r;
          end
          if (pick >= 0) begin
            m_row = pick; m_last = pick;
            for (int c = 0; c < COLS; c++)
              if (m_flag[pick][c]) begin
                m_cols.push_back(c);
                m_flag[pick][c] = 0;
              end
            m_breq = 1; m_wreqn = 1; m_addr = 0; m_phase = 1;
          end
        end
        1: if (tog) begin m_addr = m_row; m_wreqn = 0; m_phase = 2; end
        2: if (tog) begin
          m_wreqn = 1;
          if (m_cols.size() > 0) m_phase = 3;
          else begin m_breq = 0; m_addr = 0; m_phase = 0; end
        end
        default: begin m_addr = m_cols.pop_front(); m_wreqn = 0; m_phase = 2; end
      endcase
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          if (spike_in[r*COLS + c]) m_flag[r][c] = 1;
      m_ackq = ack;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(burst_req == m_breq, "R6 burst_req vs model", burst_req, m_breq);
      check(word_req_n == m_wreqn, "R4 word_req_n vs model", word_req_n, m_wreqn);
      check(int'(addr) == m_addr, "R5 addr vs model", addr, m_addr);
    end
  end

  // receiver: logs words on request edges and toggles ack after a varying delay
  int log_q[$];
  bit prev_b = 0, prev_w = 1;
  bit ack_pend = 0;
  int ack_cnt = 0;
  int dly_sel = 0;
  always @(negedge clk) begin
    if (!rst) begin
      bit edge_seen;
      edge_seen = 0;
      if (burst_req && !prev_b) begin
        log_q.push_back(-1); log_q.push_back(addr); edge_seen = 1;
      end else if (!word_req_n && prev_w) begin
        log_q.push_back(addr); edge_seen = 1;
      end
      if (edge_seen) begin
        ack_pend = 1;
        ack_cnt = (dly_sel % 4 == 1) ? 1 : (dly_sel % 4 == 2) ? 3 : (dly_sel % 4 == 3) ? 2 : 0;
        dly_sel++;
      end
      if (ack_pend) begin
        if (ack_cnt == 0) begin ack = ~ack; ack_pend = 0; end
        else ack_cnt--;
      end
      prev_b = burst_req; prev_w = word_req_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic fire(input int r, input int c);
    spike_in[r*COLS + c] = 1'b1;
  endtask

  task automatic release_spikes();
    @(negedge clk);
    spike_in = '0;
  endtask

  task automatic wait_burst();
    while (!burst_req) @(negedge clk);
  endtask

  task automatic check_log(input int exp[$], input string req);
    check(log_q.size() == exp.size(), {req, " word count"}, log_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < log_q.size(); i++)
      check(log_q[i] == exp[i], {req, " word"}, log_q[i], exp[i]);
    log_q.delete();
  endtask

  initial begin
    int exp_q[$];
    repeat (2) @(negedge clk);
    check(burst_req == 0, "R1 burst_req in reset", burst_req, 0);
    check(word_req_n == 1, "R1 word_req_n in reset", word_req_n, 1);
    check(addr == 0, "R1 addr in reset", addr, 0);
    rst = 1'b0;

    // R2 R3 R4: one row with several neurons, plus a second row
    @(negedge clk);
    fire(2, 5); fire(2, 1); fire(5, 0);
    release_spikes();
    repeat (60) @(negedge clk);
    exp_q = '{-1, 0, 2, 1, 5, -1, 0, 5, 0};
    check_log(exp_q, "R3 R4 grouped ascending burst");

    // R7: locked row keeps late spikes for the next burst
    fire(3, 4);
    release_spikes();
    wait_burst();
    fire(3, 4); fire(3, 6);
    release_spikes();
    repeat (60) @(negedge clk);
    exp_q = '{-1, 0, 3, 4, -1, 0, 3, 4, 6};
    check_log(exp_q, "R7 late spikes deferred");

    // R8 R10: round-robin with wrap, duplicate pulses merge
    fire(1, 0); fire(6, 7);
    release_spikes();
    wait_burst();
    fire(0, 3); fire(4, 2);
    release_spikes();
    fire(4, 2);
    release_spikes();
    repeat (90) @(negedge clk);
    exp_q = '{-1, 0, 6, 7, -1, 0, 0, 3, -1, 0, 1, 0, -1, 0, 4, 2};
    check_log(exp_q, "R8 R10 round-robin order");

    // R4: a full row
    for (int c = 0; c < COLS; c++) fire(7, c);
    release_spikes();
    repeat (80) @(negedge clk);
    exp_q = '{-1, 0, 7, 0, 1, 2, 3, 4, 5, 6, 7};
    check_log(exp_q, "R4 full row");

    // R9: nothing is resent once flags are cleared
    repeat (40) @(negedge clk);
    check(log_q.size() == 0, "R9 no resend", log_q.size(), 0);
    check(burst_req == 0, "R9 idle after drain", burst_req, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule